// File: doc/BRIEF.md
# Sub-Pixel Candidate Argmin Tree

This block picks the best of a set of sub-pixel motion candidates. The cost of every candidate, one per displacement in a square grid of side 2K−1 around an integer-pixel vector, arrives in parallel on a single cycle. The block pushes them through a binary tree of two-input comparators, one register stage per tree level. It returns the smallest cost together with the signed horizontal and vertical offset of the candidate that produced it.

The offsets are not supplied by the caller. Each input slot is tagged inside the block with its own grid position. The tag then rides up the tree beside its cost, steered by the same comparison that picks the cost. Raising K makes the tree deeper and the latency longer, but a fresh candidate set can still enter on every cycle.

Top module: `subpel_argmin_tree`

## Requirements
- R1: The block takes NCAND = (2K−1)² costs of COST_W bits each; the cost of candidate i sits at bits [i*COST_W +: COST_W] of `cand_cost`.
- R2: For each accepted set, `best_cost` equals the smallest of the NCAND unsigned costs.
- R3: Candidate i carries the offsets dx = (i mod (2K−1)) − (K−1) and dy = (i div (2K−1)) − (K−1), given as CRD_W-bit two's complement on `best_dx` / `best_dy`; both stay within −(K−1)..K−1.
- R4: When several candidates share the minimum cost, the one with the lowest index wins.
- R5: `out_valid` is `in_valid` delayed by exactly LAT = ceil(log2(NCAND)) cycles, and the result belongs to the set that entered LAT cycles earlier.
- R6: A new set may be presented on every cycle; back-to-back sets produce results on consecutive cycles in entry order.
- R7: While `rst_n` is low, and after it rises until the first result, `out_valid`, `best_cost`, `best_dx` and `best_dy` are all zero; a set in flight when reset is asserted produces no result.
- R8: While `out_valid` is low after a result, `best_cost`, `best_dx` and `best_dy` hold the last result.
- R9: At a tree level with an odd number of entries, the unpaired (highest-index) entry passes through unchanged, so the last candidate can win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a candidate set on `cand_cost` |
| cand_cost | input | NCAND*COST_W | Packed unsigned costs, candidate 0 in the low bits |
| out_valid | output | 1 | Marks a result on the outputs |
| best_cost | output | COST_W | Smallest cost of the set |
| best_dx | output | CRD_W | Horizontal offset of the winner, two's complement |
| best_dy | output | CRD_W | Vertical offset of the winner, two's complement |

## Verification
The bench places the minimum at the centre, at the first slot and at the unpaired last slot. A tree that dropped the odd entry would never report offset (+1,+1). Sets with all costs equal, or with two equal minima far apart, expose a comparator that keeps the higher operand on ties, since it would report the wrong offset with the right cost. Costs at full scale and at zero catch truncated compares. Back-to-back sets, a wait between results and a reset asserted mid-flight expose a valid pipe of the wrong length, outputs that drift when idle, and stale results that leak out after reset.

// File: rtl/argmin_pkg.sv
package argmin_pkg;

    // number of entries at tree level l for n leaves
    function automatic int lvl_size(input int n, input int l);
        int s;
        s = n;
        for (int j = 0; j < l; j++) s = (s + 1) / 2;
        return s;
    endfunction

    // number of comparator levels to reduce n entries to one
    function automatic int num_lvls(input int n);
        int s;
        int c;
        s = n;
        c = 0;
        while (s > 1) begin
            s = (s + 1) / 2;
            c++;
        end
        return c;
    endfunction

    // entry offset of level l inside the concatenated level chain
    function automatic int lvl_off(input int n, input int l);
        int o;
        o = 0;
        for (int j = 0; j < l; j++) o += lvl_size(n, j);
        return o;
    endfunction

endpackage

// File: rtl/argmin_node.sv
module argmin_node #(
    parameter int COST_W = 16,
    parameter int CRD_W  = 4
) (
    input  logic [COST_W+2*CRD_W-1:0] lo_ent,
    input  logic [COST_W+2*CRD_W-1:0] hi_ent,
    output logic [COST_W+2*CRD_W-1:0] win_ent
);
    localparam int EW = COST_W + 2 * CRD_W;

    logic [COST_W-1:0] lo_cost;
    logic [COST_W-1:0] hi_cost;
    logic              take_hi;

    assign lo_cost = lo_ent[EW-1 -: COST_W];
    assign hi_cost = hi_ent[EW-1 -: COST_W];

    // strict compare: equal costs keep the lower-indexed operand
    assign take_hi = hi_cost < lo_cost;

    // cost and both offsets share one select
    assign win_ent = take_hi ? hi_ent : lo_ent;
endmodule

// File: rtl/argmin_level.sv
module argmin_level #(
    parameter int IN_N   = 9,
    parameter int COST_W = 16,
    parameter int CRD_W  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              vld_i,
    input  logic [IN_N*(COST_W+2*CRD_W)-1:0]  ent_i,
    output logic                              vld_o,
    output logic [((IN_N+1)/2)*(COST_W+2*CRD_W)-1:0] ent_o
);
    localparam int EW    = COST_W + 2 * CRD_W;
    localparam int OUT_N = (IN_N + 1) / 2;
    localparam int NPAIR = IN_N / 2;
    localparam bit ODD   = (IN_N % 2) == 1;

    typedef struct packed {
        logic                  vld;
        logic [OUT_N*EW-1:0]   ent;
    } lvl_st_t;

    lvl_st_t st_d, st_q;
    logic [OUT_N*EW-1:0] pick;

    for (genvar j = 0; j < NPAIR; j++) begin : g_pair
        argmin_node #(.COST_W(COST_W), .CRD_W(CRD_W)) u_node (
            .lo_ent (ent_i[(2*j)*EW +: EW]),
            .hi_ent (ent_i[(2*j+1)*EW +: EW]),
            .win_ent(pick[j*EW +: EW])
        );

        // R2: survivor is no larger than either operand
        assert_pair_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> (ent_o[j*EW+EW-1 -: COST_W] <= $past(ent_i[(2*j)*EW+EW-1 -: COST_W]))
                   && (ent_o[j*EW+EW-1 -: COST_W] <= $past(ent_i[(2*j+1)*EW+EW-1 -: COST_W])));

        // R4: on equal costs the lower operand's tag survives
        assert_tie_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_i && ent_i[(2*j)*EW+EW-1 -: COST_W] == ent_i[(2*j+1)*EW+EW-1 -: COST_W])
            |=> ent_o[j*EW +: EW] == $past(ent_i[(2*j)*EW +: EW]));
    end

    if (ODD) begin : g_odd
        assign pick[NPAIR*EW +: EW] = ent_i[(IN_N-1)*EW +: EW];

        // R9: unpaired entry crosses the level untouched
        assert_odd_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> ent_o[NPAIR*EW +: EW] == $past(ent_i[(IN_N-1)*EW +: EW]));
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) st_d.ent = pick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign ent_o = st_q.ent;
endmodule

// File: rtl/subpel_argmin_tree.sv
module subpel_argmin_tree
    import argmin_pkg::*;
#(
    parameter int K      = 2,
    parameter int COST_W = 16,
    parameter int CRD_W  = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [(2*K-1)*(2*K-1)*COST_W-1:0]     cand_cost,
    output logic                                  out_valid,
    output logic [COST_W-1:0]                     best_cost,
    output logic [CRD_W-1:0]                      best_dx,
    output logic [CRD_W-1:0]                      best_dy
);
    localparam int SIDE  = 2 * K - 1;
    localparam int NCAND = SIDE * SIDE;
    localparam int EW    = COST_W + 2 * CRD_W;
    localparam int LAT   = num_lvls(NCAND);
    localparam int TOT   = lvl_off(NCAND, LAT + 1);
    localparam int FOFF  = lvl_off(NCAND, LAT);

    logic [TOT*EW-1:0] chain;
    logic [LAT:0]      vchain;

    assign vchain[0] = in_valid;

    // tag each slot with its grid offset around the integer vector
    for (genvar i = 0; i < NCAND; i++) begin : g_tag
        localparam int DX = (i % SIDE) - (K - 1);
        localparam int DY = (i / SIDE) - (K - 1);
        assign chain[i*EW +: EW] = {cand_cost[i*COST_W +: COST_W],
                                    CRD_W'(DX), CRD_W'(DY)};
    end

    for (genvar l = 0; l < LAT; l++) begin : g_lvl
        localparam int IN_N = lvl_size(NCAND, l);
        localparam int OUT_N = lvl_size(NCAND, l + 1);
        localparam int IOFF = lvl_off(NCAND, l);
        localparam int OOFF = lvl_off(NCAND, l + 1);
        argmin_level #(.IN_N(IN_N), .COST_W(COST_W), .CRD_W(CRD_W)) u_lvl (
            .clk  (clk),
            .rst_n(rst_n),
            .vld_i(vchain[l]),
            .ent_i(chain[IOFF*EW +: IN_N*EW]),
            .vld_o(vchain[l+1]),
            .ent_o(chain[OOFF*EW +: OUT_N*EW])
        );
    end

    assign out_valid = vchain[LAT];
    assign best_cost = chain[FOFF*EW + EW - 1 -: COST_W];
    assign best_dx   = chain[FOFF*EW + CRD_W +: CRD_W];
    assign best_dy   = chain[FOFF*EW +: CRD_W];

    // cycles since reset, saturating, so latency checks never reach before reset
    logic [7:0] warm_d, warm_q;
    always_comb begin
        warm_d = warm_q;
        if (warm_q < 8'(LAT)) warm_d = warm_q + 8'd1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    // R5: valid emerges exactly LAT cycles after entry
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 8'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    // R3: reported offsets stay inside the candidate window
    assert_coord_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(best_dx) >= -(K-1)) && ($signed(best_dx) <= (K-1))
                   && ($signed(best_dy) >= -(K-1)) && ($signed(best_dy) <= (K-1)));

    // R8: idle cycles leave the result untouched
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && warm_q >= 8'(LAT)) |-> $stable(best_cost));
endmodule

// File: tb/sim_subpel_argmin_tree.sv
module sim_subpel_argmin_tree;
    localparam int K = 2;
    localparam int COST_W = 16;
    localparam int CRD_W = 4;
    localparam int SIDE = 2 * K - 1;
    localparam int NC = SIDE * SIDE;
    localparam int LAT = 4;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NC*COST_W-1:0] cand_cost = '0;
    logic out_valid;
    logic [COST_W-1:0] best_cost;
    logic [CRD_W-1:0] best_dx, best_dy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    subpel_argmin_tree #(.K(K), .COST_W(COST_W), .CRD_W(CRD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cand_cost(cand_cost),
        .out_valid(out_valid), .best_cost(best_cost),
        .best_dx(best_dx), .best_dy(best_dy)
    );

    // costs per slot, followed by the expected winning slot
    localparam logic [15:0] VEC [0:NV-1][0:NC-1] = '{
        '{16'd50, 16'd40, 16'd30, 16'd20, 16'd5,  16'd60, 16'd70, 16'd80, 16'd90},
        '{16'd1,  16'd2,  16'd3,  16'd4,  16'd5,  16'd6,  16'd7,  16'd8,  16'd9},
        '{16'd9,  16'd9,  16'd9,  16'd9,  16'd9,  16'd9,  16'd9,  16'd9,  16'd3},
        '{16'd7,  16'd7,  16'd7,  16'd7,  16'd7,  16'd7,  16'd7,  16'd7,  16'd7},
        '{16'd10, 16'd10, 16'd10, 16'd2,  16'd10, 16'd10, 16'd2,  16'd10, 16'd10},
        '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFE, 16'hFFFF, 16'hFFFF, 16'hFFFF},
        '{16'd5,  16'd5,  16'd5,  16'd5,  16'd5,  16'd5,  16'd5,  16'd0,  16'd0},
        '{16'd100, 16'd200, 16'd16, 16'd300, 16'd17, 16'd400, 16'd500, 16'd600, 16'd700}
    };
    localparam int EXP_IDX [0:NV-1] = '{4, 0, 8, 0, 3, 5, 7, 2};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int v);
        for (int c = 0; c < NC; c++) cand_cost[c*COST_W +: COST_W] = VEC[v][c];
    endtask

    task automatic check_result(input int v, input string req);
        int idx;
        idx = EXP_IDX[v];
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " cost"}, int'(best_cost), int'(VEC[v][idx]));
        chk({req, " dx"}, int'($signed(best_dx)), (idx % SIDE) - (K - 1));
        chk({req, " dy"}, int'($signed(best_dy)), (idx / SIDE) - (K - 1));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        chk("R7 reset valid", int'(out_valid), 0);
        chk("R7 reset cost", int'(best_cost), 0);
        chk("R7 reset dx", int'(best_dx), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R3 R4 R5 R8 R9
        for (int v = 0; v < NV; v++) begin
            load(v);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            cand_cost = '0;
            repeat (LAT - 2) @(negedge clk);
            chk("R5 early valid", int'(out_valid), 0);
            @(negedge clk);
            check_result(v, "R2 R3 R4 R9 table");
            @(negedge clk);
            chk("R5 single pulse", int'(out_valid), 0);
            chk("R8 hold cost", int'(best_cost), int'(VEC[v][EXP_IDX[v]]));
        end

        // R6: back-to-back sets
        for (int v = 0; v < 3; v++) begin
            load(v + 2);
            in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (LAT - 3) @(negedge clk);
        for (int v = 0; v < 3; v++) begin
            check_result(v + 2, "R6 back-to-back");
            @(negedge clk);
        end
        chk("R6 stream end", int'(out_valid), 0);

        // R7: reset in flight drops the pending set
        load(0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < LAT + 1; c++) begin
            chk("R7 flush valid", int'(out_valid), 0);
            @(negedge clk);
        end
        chk("R7 flush cost", int'(best_cost), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule